// File: doc/BRIEF.md
# Auto-Restart Fault Supervisor

This block sits in the digital control section of an off-line flyback controller and decides when switching must stop and the converter must go through a fresh start. It receives comparator flags from the analog front end: feedback above the overload level, two supply overvoltage levels, an overtemperature flag, a flag that the blanking/restart pin has been pulled low externally, an undervoltage flag, and a flag that the blanking/restart pin has charged to its upper level. It also receives the soft-start-active and burst-mode-active status of the controller.

An overload is qualified in two stages. A fixed blanking window must first elapse with feedback held high. The block then releases the clamp on the external extension capacitor. The analog charging of that capacitor lies outside this block. Once the pin comparator reports the upper level, that level must hold for a short spike window before the fault is declared. The other faults have their own filters. In the auto-restart state the gate stays off until the supply has dropped through undervoltage and recovered. A one-cycle restart request then starts a new soft start, and every fault is checked again from a clean state. All windows are counted in clock cycles of the supervisor clock.

Top module: `ar_fault_sup`

## Requirements
- R1: While reset is asserted, autoRestart=1, gateOff=1, clampRelease=0, restartReq=0 and faultCause=0.
- R2: After BLANK_CYCLES consecutive clocks with fbHigh=1, clampRelease goes to 1. Overload auto-restart follows once baHigh has been sampled high on SPIKE_CYCLES consecutive clocks after the release, and is entered on the clock after that.
- R3: If fbHigh drops before qualification, clampRelease returns to 0 on the next clock. A later overload restarts the full blanking window, and an interruption of baHigh restarts the spike window.
- R4: If vccOvSoft, fbHigh and softStartActive are all 1 at a clock edge, auto-restart is entered at that edge. No subset of the three has this effect.
- R5: vccOvHard sampled high on HARDOV_CYCLES consecutive clocks causes auto-restart one clock later. Shorter pulses are filtered out, and nothing is counted while burstActive=1.
- R6: overTemp=1 at a clock edge in normal operation enters auto-restart at that edge.
- R7: Once STARTBLANK_CYCLES clocks have passed since the restart, extDisable forces gateOff=1 combinationally. If it is held for SPIKE_CYCLES further clocks, auto-restart is entered. During the first STARTBLANK_CYCLES clocks after a restart, extDisable has no effect.
- R8: vccUnder=1 during normal operation enters auto-restart at the next edge.
- R9: Once in auto-restart, the block stays there until vccUnder has been 1 and then returns to 0. On that edge it resumes normal operation with restartReq=1 for exactly one clock. A fault still present is caught again after the restart.
- R10: faultCause records the cause of the latest entry: 1 overload, 2 soft-start overvoltage, 3 sustained overvoltage, 4 overtemperature, 5 external disable, 6 undervoltage. When causes coincide, priority runs 4, 3, 2, 5, 1, 6 from highest to lowest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Supervisor clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fbHigh | input | 1 | Feedback above overload level |
| baHigh | input | 1 | Blanking/restart pin at or above upper level |
| extDisable | input | 1 | Blanking/restart pin pulled below disable level |
| vccOvSoft | input | 1 | Supply above lower overvoltage level |
| vccOvHard | input | 1 | Supply above upper overvoltage level |
| overTemp | input | 1 | Junction overtemperature flag |
| vccUnder | input | 1 | Supply below undervoltage lockout |
| softStartActive | input | 1 | Soft start in progress |
| burstActive | input | 1 | Burst mode active |
| gateOff | output | 1 | Switching disabled |
| autoRestart | output | 1 | Block is in auto-restart |
| clampRelease | output | 1 | Release the extension capacitor clamp |
| restartReq | output | 1 | One-cycle request to begin soft start |
| faultCause | output | 3 | Cause of latest auto-restart entry |

## Verification
The bench builds the block with BLANK_CYCLES=16, SPIKE_CYCLES=3, HARDOV_CYCLES=5 and STARTBLANK_CYCLES=8. With windows this short, every overload path can be swept over extension delays of zero to four cycles. Overvoltage pulses of every length around the filter threshold can be applied, and all eight soft-start overvoltage input combinations can be tried. The startup blank, the external-disable filter and the cause priorities each stay within a few dozen cycles, so each is traced cycle by cycle against arithmetic expectations.

// File: rtl/ar_pkg.sv
package ar_pkg;

  typedef enum logic [1:0] {
    ST_RUN      = 2'd0,
    ST_HALT     = 2'd1,
    ST_RECHARGE = 2'd2
  } arState_t;

  typedef enum logic [2:0] {
    CAUSE_NONE     = 3'd0,
    CAUSE_OVERLOAD = 3'd1,
    CAUSE_SOFT_OV  = 3'd2,
    CAUSE_HARD_OV  = 3'd3,
    CAUSE_HOT      = 3'd4,
    CAUSE_EXT      = 3'd5,
    CAUSE_UV       = 3'd6
  } cause_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrWindows;
  } ctlStrobe_t;

  // qualification status from datapath to control
  typedef struct packed {
    logic blankDone;
    logic spikeDone;
    logic ovpDone;
    logic startDone;
    logic extDone;
  } dpFlags_t;

endpackage

// File: rtl/ar_win_cnt.sv
module ar_win_cnt #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic clr,
  input  logic en,
  output logic done
);
  localparam int CW = (LIMIT < 1) ? 1 : $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               cnt <= '0;
    else if (clr || !en)     cnt <= '0;
    else if (cnt != CW'(LIMIT)) cnt <= cnt + CW'(1);
  end

  assign done = (cnt == CW'(LIMIT));

  // R3
  win_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!en && LIMIT > 0) |=> !done);

  // R2
  win_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && en && !clr) |=> done);

endmodule

// File: rtl/ar_datapath.sv
module ar_datapath
  import ar_pkg::*;
#(
  parameter int BLANK_CYCLES      = 20000,
  parameter int SPIKE_CYCLES      = 30,
  parameter int HARDOV_CYCLES     = 120,
  parameter int STARTBLANK_CYCLES = 1000
) (
  input  logic       clk,
  input  logic       rstN,
  input  ctlStrobe_t strobe,
  input  logic       fbHigh,
  input  logic       baHigh,
  input  logic       extDisable,
  input  logic       vccOvHard,
  input  logic       burstActive,
  output dpFlags_t   flags
);
  logic blankDone, spikeDone, ovpDone, startDone, extDone;

  ar_win_cnt #(.LIMIT(BLANK_CYCLES)) u_blank (
    .clk(clk), .rstN(rstN), .clr(strobe.clrWindows),
    .en(fbHigh), .done(blankDone));

  ar_win_cnt #(.LIMIT(SPIKE_CYCLES)) u_spike (
    .clk(clk), .rstN(rstN), .clr(strobe.clrWindows),
    .en(fbHigh && blankDone && baHigh), .done(spikeDone));

  ar_win_cnt #(.LIMIT(HARDOV_CYCLES)) u_ovp (
    .clk(clk), .rstN(rstN), .clr(strobe.clrWindows),
    .en(vccOvHard && !burstActive), .done(ovpDone));

  ar_win_cnt #(.LIMIT(STARTBLANK_CYCLES)) u_start (
    .clk(clk), .rstN(rstN), .clr(strobe.clrWindows),
    .en(1'b1), .done(startDone));

  ar_win_cnt #(.LIMIT(SPIKE_CYCLES)) u_ext (
    .clk(clk), .rstN(rstN), .clr(strobe.clrWindows),
    .en(extDisable && startDone), .done(extDone));

  always_comb begin
    flags.blankDone = blankDone;
    flags.spikeDone = spikeDone;
    flags.ovpDone   = ovpDone;
    flags.startDone = startDone;
    flags.extDone   = extDone;
  end

  // R2
  spike_after_blank_chk: assert property (@(posedge clk) disable iff (!rstN)
    spikeDone |-> blankDone);

  // R5
  burst_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    burstActive |=> !ovpDone);

endmodule

// File: rtl/ar_control.sv
module ar_control
  import ar_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  dpFlags_t   flags,
  input  logic       fbHigh,
  input  logic       extDisable,
  input  logic       vccOvSoft,
  input  logic       overTemp,
  input  logic       vccUnder,
  input  logic       softStartActive,
  output ctlStrobe_t strobe,
  output logic       gateOff,
  output logic       autoRestart,
  output logic       clampRelease,
  output logic       restartReq,
  output logic [2:0] faultCause
);
  arState_t state, nextState;
  cause_t   cause, nextCause;
  logic     softOv;

  assign softOv = vccOvSoft && fbHigh && softStartActive;

  always_comb begin
    nextState = state;
    nextCause = cause;
    case (state)
      ST_RUN: begin
        if (overTemp) begin
          nextState = ST_HALT;     nextCause = CAUSE_HOT;
        end else if (flags.ovpDone) begin
          nextState = ST_HALT;     nextCause = CAUSE_HARD_OV;
        end else if (softOv) begin
          nextState = ST_HALT;     nextCause = CAUSE_SOFT_OV;
        end else if (flags.extDone) begin
          nextState = ST_HALT;     nextCause = CAUSE_EXT;
        end else if (flags.spikeDone) begin
          nextState = ST_HALT;     nextCause = CAUSE_OVERLOAD;
        end else if (vccUnder) begin
          nextState = ST_RECHARGE; nextCause = CAUSE_UV;
        end
      end
      ST_HALT:     if (vccUnder)  nextState = ST_RECHARGE;
      ST_RECHARGE: if (!vccUnder) nextState = ST_RUN;
      default:     nextState = ST_RECHARGE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_RECHARGE;
      cause      <= CAUSE_NONE;
      restartReq <= 1'b0;
    end else begin
      state      <= nextState;
      cause      <= nextCause;
      restartReq <= (state == ST_RECHARGE) && !vccUnder;
    end
  end

  assign strobe.clrWindows = (state != ST_RUN);
  assign autoRestart  = (state != ST_RUN);
  assign gateOff      = (state != ST_RUN) || (extDisable && flags.startDone);
  assign clampRelease = (state == ST_RUN) && flags.blankDone;
  assign faultCause   = cause;

  // R6
  hot_trip_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && overTemp) |=> (autoRestart && faultCause == 3'd4));

  // R9
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HALT && !vccUnder) |=> (state == ST_HALT));

  // R9
  restart_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    restartReq |=> !restartReq);

  // R7
  ext_blank_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && !flags.startDone) |-> !gateOff);

endmodule

// File: rtl/ar_fault_sup.sv
module ar_fault_sup
  import ar_pkg::*;
#(
  parameter int BLANK_CYCLES      = 20000,
  parameter int SPIKE_CYCLES      = 30,
  parameter int HARDOV_CYCLES     = 120,
  parameter int STARTBLANK_CYCLES = 1000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       fbHigh,
  input  logic       baHigh,
  input  logic       extDisable,
  input  logic       vccOvSoft,
  input  logic       vccOvHard,
  input  logic       overTemp,
  input  logic       vccUnder,
  input  logic       softStartActive,
  input  logic       burstActive,
  output logic       gateOff,
  output logic       autoRestart,
  output logic       clampRelease,
  output logic       restartReq,
  output logic [2:0] faultCause
);
  ctlStrobe_t strobe;
  dpFlags_t   flags;

  ar_datapath #(
    .BLANK_CYCLES(BLANK_CYCLES), .SPIKE_CYCLES(SPIKE_CYCLES),
    .HARDOV_CYCLES(HARDOV_CYCLES), .STARTBLANK_CYCLES(STARTBLANK_CYCLES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .fbHigh(fbHigh), .baHigh(baHigh), .extDisable(extDisable),
    .vccOvHard(vccOvHard), .burstActive(burstActive), .flags(flags));

  ar_control u_ctl (
    .clk(clk), .rstN(rstN), .flags(flags),
    .fbHigh(fbHigh), .extDisable(extDisable), .vccOvSoft(vccOvSoft),
    .overTemp(overTemp), .vccUnder(vccUnder),
    .softStartActive(softStartActive), .strobe(strobe),
    .gateOff(gateOff), .autoRestart(autoRestart),
    .clampRelease(clampRelease), .restartReq(restartReq),
    .faultCause(faultCause));

endmodule

// File: tb/ar_fault_sup_tb.sv
module ar_fault_sup_tb;
  localparam int PERIOD = 10;
  localparam int BLANK  = 16;
  localparam int SPIKE  = 3;
  localparam int HOV    = 5;
  localparam int SBLK   = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic fbHigh = 0, baHigh = 0, extDisable = 0, vccOvSoft = 0, vccOvHard = 0;
  logic overTemp = 0, vccUnder = 1, softStartActive = 0, burstActive = 0;
  logic gateOff, autoRestart, clampRelease, restartReq;
  logic [2:0] faultCause;

  int nChecks = 0;
  int nFail = 0;
  bit summaryDone = 0;

  always #(PERIOD/2) clk = ~clk;

  ar_fault_sup #(
    .BLANK_CYCLES(BLANK), .SPIKE_CYCLES(SPIKE),
    .HARDOV_CYCLES(HOV), .STARTBLANK_CYCLES(SBLK)
  ) u_dut (
    .clk(clk), .rstN(rstN), .fbHigh(fbHigh), .baHigh(baHigh),
    .extDisable(extDisable), .vccOvSoft(vccOvSoft), .vccOvHard(vccOvHard),
    .overTemp(overTemp), .vccUnder(vccUnder),
    .softStartActive(softStartActive), .burstActive(burstActive),
    .gateOff(gateOff), .autoRestart(autoRestart),
    .clampRelease(clampRelease), .restartReq(restartReq),
    .faultCause(faultCause));

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #(PERIOD/4);
  endtask

  task automatic summary();
    if (!summaryDone) begin
      summaryDone = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    end
  endtask

  // R9 supply dip and recovery, ends on the restart edge
  task automatic restart();
    vccUnder = 1;
    tick();
    chk("R9 off during dip", autoRestart, 1);
    vccUnder = 0;
    tick();
    chk("R9 restart pulse", restartReq, 1);
    chk("R9 running after restart", autoRestart, 0);
  endtask

  initial begin
    #(PERIOD * 200000);
    nFail++;
    $display("FAIL watchdog: actual 1 expected 0");
    summary();
    $finish;
  end

  initial begin
    // R1 reset values
    #(PERIOD*2 + 2);
    chk("R1 autoRestart", autoRestart, 1);
    chk("R1 gateOff", gateOff, 1);
    chk("R1 clampRelease", clampRelease, 0);
    chk("R1 restartReq", restartReq, 0);
    chk("R1 faultCause", faultCause, 0);
    rstN = 1;
    tick();
    vccUnder = 0;
    tick();
    chk("R9 first start pulse", restartReq, 1);
    tick();
    chk("R9 pulse one cycle", restartReq, 0);

    // R2 overload sweep over extension delays
    for (int d = 0; d <= 4; d++) begin
      int faultK;
      faultK = BLANK + d + SPIKE + 1;
      fbHigh = 1; baHigh = 0;
      for (int k = 1; k <= faultK; k++) begin
        tick();
        chk("R2 clamp", clampRelease, (k >= BLANK && k < faultK) ? 1 : 0);
        chk("R2 autoRestart", autoRestart, (k >= faultK) ? 1 : 0);
        if (k >= BLANK + d) baHigh = 1;
      end
      chk("R10 overload cause", faultCause, 1);
      chk("R2 gate off", gateOff, 1);
      fbHigh = 0; baHigh = 0;
      for (int k = 0; k < 3; k++) begin
        tick();
        chk("R9 hold until dip", autoRestart, 1);
      end
      restart();
    end

    // R3 early clearing of overload
    fbHigh = 1;
    for (int k = 1; k <= BLANK + 2; k++) tick();
    chk("R3 clamp released", clampRelease, 1);
    fbHigh = 0;
    tick();
    chk("R3 clamp re-engaged", clampRelease, 0);
    fbHigh = 1;
    for (int k = 1; k <= BLANK; k++) begin
      tick();
      chk("R3 window restarts", clampRelease, (k >= BLANK) ? 1 : 0);
    end
    baHigh = 1;
    for (int k = 1; k < SPIKE; k++) tick();
    baHigh = 0;
    tick();
    chk("R3 spike interrupted", autoRestart, 0);
    baHigh = 1;
    for (int k = 1; k < SPIKE; k++) tick();
    chk("R3 spike window restarts", autoRestart, 0);
    baHigh = 0; fbHigh = 0;
    tick(); tick();
    chk("R3 no fault", autoRestart, 0);

    // R4 soft-start overvoltage combinations
    for (int c = 0; c < 8; c++) begin
      softStartActive = c[0]; vccOvSoft = c[1]; fbHigh = c[2];
      tick();
      softStartActive = 0; vccOvSoft = 0; fbHigh = 0;
      chk("R4 combo", autoRestart, (c == 7) ? 1 : 0);
      if (c == 7) begin
        chk("R10 soft ov cause", faultCause, 2);
        restart();
      end
      tick();
    end

    // R5 sustained overvoltage pulse lengths
    for (int len = 1; len <= HOV + 1; len++) begin
      vccOvHard = 1;
      for (int k = 1; k <= HOV + 1; k++) begin
        tick();
        if (k == len) vccOvHard = 0;
      end
      chk("R5 pulse length", autoRestart, (len >= HOV) ? 1 : 0);
      if (len >= HOV) begin
        chk("R10 hard ov cause", faultCause, 3);
        restart();
      end
      tick();
    end
    burstActive = 1; vccOvHard = 1;
    for (int k = 0; k < HOV + 3; k++) tick();
    chk("R5 masked in burst", autoRestart, 0);
    burstActive = 0; vccOvHard = 0;
    tick();

    // R6 overtemperature, R9 persisting fault
    overTemp = 1;
    tick();
    chk("R6 immediate", autoRestart, 1);
    chk("R10 hot cause", faultCause, 4);
    chk("R6 gate off", gateOff, 1);
    restart();
    tick();
    chk("R9 persisting fault returns", autoRestart, 1);
    overTemp = 0;
    restart();
    tick(); tick();
    chk("R9 normal after clear", autoRestart, 0);

    // R10 coincident causes
    overTemp = 1; vccOvSoft = 1; fbHigh = 1; softStartActive = 1;
    tick();
    overTemp = 0; vccOvSoft = 0; fbHigh = 0; softStartActive = 0;
    chk("R10 hot beats soft ov", faultCause, 4);
    restart();
    overTemp = 1; vccUnder = 1;
    tick();
    chk("R10 hot beats uv", faultCause, 4);
    overTemp = 0;
    tick();
    vccUnder = 0;
    tick();
    chk("R9 restart after halt dip", restartReq, 1);

    // R7 external disable during and after startup blank
    extDisable = 1;
    for (int k = 1; k <= SBLK + SPIKE + 1; k++) begin
      tick();
      chk("R7 gate", gateOff, (k >= SBLK) ? 1 : 0);
      chk("R7 autoRestart", autoRestart, (k >= SBLK + SPIKE + 1) ? 1 : 0);
    end
    chk("R10 ext cause", faultCause, 5);
    extDisable = 0;
    restart();
    for (int k = 0; k < SBLK + 1; k++) tick();
    extDisable = 1;
    #1;
    chk("R7 gate at once", gateOff, 1);
    for (int k = 1; k < SPIKE; k++) tick();
    extDisable = 0;
    #1;
    chk("R7 gate released", gateOff, 0);
    tick(); tick();
    chk("R7 short pulse filtered", autoRestart, 0);

    // R8 undervoltage during run
    vccUnder = 1;
    tick();
    chk("R8 uv entry", autoRestart, 1);
    chk("R10 uv cause", faultCause, 6);
    chk("R8 no pulse yet", restartReq, 0);
    vccUnder = 0;
    tick();
    chk("R8 restart", restartReq, 1);
    tick();
    chk("R9 pulse ends", restartReq, 0);

    summary();
    $finish;
  end
endmodule